// File: doc/BRIEF.md
# Interrupt status and mask controller

This block collects interrupt requests from peripherals into a status register and gates them with a mask register. Both registers sit in a small I/O window. The status register is at byte offset 0x070 and the mask register is at byte offset 0x074. Software reaches them with 16-bit or 32-bit accesses. A one-cycle pulse on a peripheral request line sets the matching status bit.

Software clears status bits by writing the status register. The written value does not load the register. It acknowledges bits: every status bit that is zero in the written value, or zero in the mask, is cleared. Two configuration inputs can force status bit 7 (serial port) and bit 9 (sound unit) high just before a status write is applied.

The CPU interrupt request is high while any status bit and its mask bit are both set. It is held by a two-state machine: `ST_QUIET` and `ST_RAISED`. The transition `raise` is taken when the next-cycle status AND mask is non-zero. The transition `drop` is taken when it becomes zero. Because the machine looks at next-cycle values, the output follows a register write in the same cycle that the registers change.

Top module: `intc_ctrl`

## Requirements
- R1: After reset, the status register, the mask register and `cpu_irq` are all zero.
- R2: A 32-bit write at offset 0x070 + 4 (0x074) loads all 32 mask bits, and a 32-bit read there returns them.
- R3: A 16-bit write to the mask register replaces mask bits [15:0] and leaves bits [31:16] unchanged.
- R4: A write to the status register sets each affected bit to old status AND mask AND written value, so writing 0 to a bit acknowledges it.
- R5: A 16-bit write to the status register (offset 0x070) changes only bits [15:0], and bits [31:16] keep their value.
- R6: A pulse on `periph_req[i]` sets status bit i whatever the mask is. If the same bit is set and acknowledged in one cycle, the set wins.
- R7: During a status write, `force_serial` sets bit 7 and `force_sound` sets bit 9 before the acknowledge is applied. With no status write, these inputs have no effect.
- R8: `cpu_irq` equals the OR of (status AND mask) at all times, so a mask write that uncovers a pending bit raises `cpu_irq` in the cycle right after the write.
- R9: Writes at any offset other than 0x070 and 0x074 change neither register, and reads there return zero.
- R10: A 16-bit read (`acc_wide`=0) returns bits [15:0] of the selected register, zero-extended to 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_wr | input | 1 | Register write strobe, one cycle per write |
| acc_addr | input | ADDR_W | Byte offset of the access inside the I/O window |
| acc_wide | input | 1 | 1 for a 32-bit access, 0 for a 16-bit access (bits [15:0]) |
| acc_wdata | input | DATA_W | Write data |
| acc_rdata | output | DATA_W | Read data for `acc_addr`, combinational |
| periph_req | input | NUM_SRC | Peripheral request pulses; bit i sets status bit i |
| force_serial | input | 1 | Forces status bit 7 during a status write |
| force_sound | input | 1 | Forces status bit 9 during a status write |
| cpu_irq | output | 1 | Interrupt request to the CPU |

## Verification
The bench builds the block with DATA_W=32 and NUM_SRC=20, not the default of 11 sources. With 20 sources, peripheral pulses can set status bits in the upper half-word. This is what lets the bench see that a 16-bit status write leaves bits [31:16] alone. The forced bits 7 and 9 stay inside the source range, so the bench can compare forced sets against pulse sets. The bench also checks set-versus-acknowledge priority, and that the request output rises and falls on mask writes.

// File: rtl/intc_pkg.sv
package intc_pkg;

    typedef enum logic [0:0] {
        ST_QUIET  = 1'b0,
        ST_RAISED = 1'b1
    } irq_state_e;

    typedef struct packed {
        logic hit_status;
        logic hit_mask;
    } reg_sel_t;

endpackage

// File: rtl/intc_decode.sv
module intc_decode #(
    parameter int ADDR_W     = 12,
    parameter int HALF_N     = 2,
    parameter int STATUS_OFF = 'h070,
    parameter int MASK_OFF   = 'h074
) (
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    wide,
    output intc_pkg::reg_sel_t      sel,
    output logic [HALF_N-1:0]       lane_en
);
    localparam logic [ADDR_W-1:0] ST_A = ADDR_W'(STATUS_OFF);
    localparam logic [ADDR_W-1:0] MK_A = ADDR_W'(MASK_OFF);

    always_comb begin
        sel.hit_status = (addr == ST_A);
        sel.hit_mask   = (addr == MK_A);
    end

    // half-word lanes touched by the access: a narrow access covers lane 0 only
    generate
        for (genvar h = 0; h < HALF_N; h++) begin : g_lane
            if (h == 0) begin : g_low
                assign lane_en[h] = 1'b1;
            end else begin : g_high
                assign lane_en[h] = wide;
            end
        end
    endgenerate
endmodule

// File: rtl/intc_mask_reg.sv
module intc_mask_reg #(
    parameter int DATA_W = 32,
    parameter int HALF_N = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_mask,
    input  logic [HALF_N-1:0] lane_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] mask_q,
    output logic [DATA_W-1:0] mask_d
);
    generate
        for (genvar h = 0; h < HALF_N; h++) begin : g_half
            assign mask_d[h*16 +: 16] = (wr_mask && lane_en[h]) ? wdata[h*16 +: 16]
                                                               : mask_q[h*16 +: 16];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) mask_q <= '0;
        else        mask_q <= mask_d;
    end
endmodule

// File: rtl/intc_status_reg.sv
module intc_status_reg #(
    parameter int DATA_W     = 32,
    parameter int HALF_N     = 2,
    parameter int NUM_SRC    = 11,
    parameter int SERIAL_BIT = 7,
    parameter int SOUND_BIT  = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_status,
    input  logic [HALF_N-1:0]  lane_en,
    input  logic [DATA_W-1:0]  wdata,
    input  logic [DATA_W-1:0]  mask_q,
    input  logic [NUM_SRC-1:0] periph_req,
    input  logic               force_serial,
    input  logic               force_sound,
    output logic [DATA_W-1:0]  status_q,
    output logic [DATA_W-1:0]  status_d
);
    logic [DATA_W-1:0] force_vec;
    logic [DATA_W-1:0] forced;
    logic [DATA_W-1:0] acked;
    logic [DATA_W-1:0] req_ext;

    always_comb begin
        force_vec             = '0;
        force_vec[SERIAL_BIT] = force_serial;
        force_vec[SOUND_BIT]  = force_sound;
        req_ext               = '0;
        req_ext[NUM_SRC-1:0]  = periph_req;
    end

    // configuration forcing applies only on the write path
    assign forced = status_q | force_vec;

    generate
        for (genvar h = 0; h < HALF_N; h++) begin : g_half
            assign acked[h*16 +: 16] = (wr_status && lane_en[h])
                ? (forced[h*16 +: 16] & mask_q[h*16 +: 16] & wdata[h*16 +: 16])
                : status_q[h*16 +: 16];
        end
    endgenerate

    // new requests dominate an acknowledge in the same cycle
    assign status_d = acked | req_ext;

    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= status_d;
    end
endmodule

// File: rtl/intc_irq_fsm.sv
module intc_irq_fsm #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] status_d,
    input  logic [DATA_W-1:0] mask_d,
    output logic              cpu_irq
);
    import intc_pkg::*;

    irq_state_e state_q;
    irq_state_e state_d;
    logic       pending_d;

    assign pending_d = |(status_d & mask_d);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_QUIET:  if (pending_d)  state_d = ST_RAISED;  // raise
            ST_RAISED: if (!pending_d) state_d = ST_QUIET;   // drop
            default:                   state_d = ST_QUIET;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_QUIET;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            ST_RAISED: cpu_irq = 1'b1;
            default:   cpu_irq = 1'b0;
        endcase
    end
endmodule

// File: rtl/intc_ctrl.sv
module intc_ctrl #(
    parameter int ADDR_W     = 12,
    parameter int DATA_W     = 32,
    parameter int NUM_SRC    = 11,
    parameter int STATUS_OFF = 'h070,
    parameter int MASK_OFF   = 'h074,
    parameter int SERIAL_BIT = 7,
    parameter int SOUND_BIT  = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               acc_wr,
    input  logic [ADDR_W-1:0]  acc_addr,
    input  logic               acc_wide,
    input  logic [DATA_W-1:0]  acc_wdata,
    output logic [DATA_W-1:0]  acc_rdata,
    input  logic [NUM_SRC-1:0] periph_req,
    input  logic               force_serial,
    input  logic               force_sound,
    output logic               cpu_irq
);
    localparam int HALF_N = DATA_W / 16;

    intc_pkg::reg_sel_t sel;
    logic [HALF_N-1:0]  lane_en;
    logic [DATA_W-1:0]  status_q, status_d;
    logic [DATA_W-1:0]  mask_q, mask_d;
    logic [DATA_W-1:0]  sel_word;

    intc_decode #(
        .ADDR_W(ADDR_W), .HALF_N(HALF_N),
        .STATUS_OFF(STATUS_OFF), .MASK_OFF(MASK_OFF)
    ) u_decode (
        .addr(acc_addr), .wide(acc_wide), .sel(sel), .lane_en(lane_en)
    );

    intc_mask_reg #(.DATA_W(DATA_W), .HALF_N(HALF_N)) u_mask (
        .clk(clk), .rst_n(rst_n),
        .wr_mask(acc_wr && sel.hit_mask), .lane_en(lane_en),
        .wdata(acc_wdata), .mask_q(mask_q), .mask_d(mask_d)
    );

    intc_status_reg #(
        .DATA_W(DATA_W), .HALF_N(HALF_N), .NUM_SRC(NUM_SRC),
        .SERIAL_BIT(SERIAL_BIT), .SOUND_BIT(SOUND_BIT)
    ) u_status (
        .clk(clk), .rst_n(rst_n),
        .wr_status(acc_wr && sel.hit_status), .lane_en(lane_en),
        .wdata(acc_wdata), .mask_q(mask_q), .periph_req(periph_req),
        .force_serial(force_serial), .force_sound(force_sound),
        .status_q(status_q), .status_d(status_d)
    );

    intc_irq_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .status_d(status_d), .mask_d(mask_d), .cpu_irq(cpu_irq)
    );

    always_comb begin
        if (sel.hit_status)    sel_word = status_q;
        else if (sel.hit_mask) sel_word = mask_q;
        else                   sel_word = '0;
        acc_rdata = acc_wide ? sel_word : {{(DATA_W-16){1'b0}}, sel_word[15:0]};
    end
endmodule

// File: rtl/intc_ctrl_chk.sv
module intc_ctrl_chk #(
    parameter int ADDR_W     = 12,
    parameter int DATA_W     = 32,
    parameter int NUM_SRC    = 11,
    parameter int STATUS_OFF = 'h070,
    parameter int MASK_OFF   = 'h074
) (
    input logic               clk,
    input logic               rst_n,
    input logic               acc_wr,
    input logic [ADDR_W-1:0]  acc_addr,
    input logic               acc_wide,
    input logic [DATA_W-1:0]  acc_wdata,
    input logic [NUM_SRC-1:0] periph_req,
    input logic               force_serial,
    input logic               force_sound,
    input logic [DATA_W-1:0]  status_q,
    input logic [DATA_W-1:0]  mask_q,
    input logic               cpu_irq
);
    logic [DATA_W-1:0] req_ext;
    logic              at_status, at_mask;

    always_comb begin
        req_ext              = '0;
        req_ext[NUM_SRC-1:0] = periph_req;
    end
    assign at_status = (acc_addr == ADDR_W'(STATUS_OFF));
    assign at_mask   = (acc_addr == ADDR_W'(MASK_OFF));

    p_mask_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_wr && acc_wide && at_mask) |=> (mask_q == $past(acc_wdata)));

    p_mask_upper_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_wr && !acc_wide && at_mask) |=> (mask_q[DATA_W-1:16] == $past(mask_q[DATA_W-1:16])));

    p_ack_no_new_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_wr && at_status && !(|periph_req) && !force_serial && !force_sound)
        |=> ((status_q & ~$past(status_q)) == '0));

    p_status_upper_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_wr && !acc_wide && at_status && !(|req_ext[DATA_W-1:16]))
        |=> (status_q[DATA_W-1:16] == $past(status_q[DATA_W-1:16])));

    p_req_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (|periph_req) |=> (($past(req_ext) & ~status_q) == '0));

    p_irq_match_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_irq == (|(status_q & mask_q)));

    p_other_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_wr && !at_status && !at_mask && !(|periph_req))
        |=> ($stable(status_q) && $stable(mask_q)));
endmodule

bind intc_ctrl intc_ctrl_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_SRC(NUM_SRC),
    .STATUS_OFF(STATUS_OFF), .MASK_OFF(MASK_OFF)
) u_chk (
    .clk(clk), .rst_n(rst_n), .acc_wr(acc_wr), .acc_addr(acc_addr),
    .acc_wide(acc_wide), .acc_wdata(acc_wdata), .periph_req(periph_req),
    .force_serial(force_serial), .force_sound(force_sound),
    .status_q(status_q), .mask_q(mask_q), .cpu_irq(cpu_irq)
);

// File: tb/intc_ctrl_bench.sv
module intc_ctrl_bench;
    localparam int ADDR_W  = 12;
    localparam int DATA_W  = 32;
    localparam int NUM_SRC = 20;
    localparam logic [ADDR_W-1:0] A_ST = 12'h070;
    localparam logic [ADDR_W-1:0] A_MK = 12'h074;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               acc_wr = 1'b0;
    logic [ADDR_W-1:0]  acc_addr = '0;
    logic               acc_wide = 1'b1;
    logic [DATA_W-1:0]  acc_wdata = '0;
    logic [DATA_W-1:0]  acc_rdata;
    logic [NUM_SRC-1:0] periph_req = '0;
    logic               force_serial = 1'b0;
    logic               force_sound = 1'b0;
    logic               cpu_irq;

    int errs = 0;
    int checks = 0;

    always #10 clk = ~clk;

    intc_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_SRC(NUM_SRC)) u_intc_ctrl (
        .clk(clk), .rst_n(rst_n), .acc_wr(acc_wr), .acc_addr(acc_addr),
        .acc_wide(acc_wide), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
        .periph_req(periph_req), .force_serial(force_serial),
        .force_sound(force_sound), .cpu_irq(cpu_irq)
    );

    task automatic check(input string req, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    // one write cycle; returns at the following falling edge, registers updated
    task automatic wr(input logic [ADDR_W-1:0] a, input logic wide, input logic [DATA_W-1:0] d);
        @(negedge clk);
        acc_wr = 1'b1; acc_addr = a; acc_wide = wide; acc_wdata = d;
        @(negedge clk);
        acc_wr = 1'b0; acc_wide = 1'b1;
    endtask

    task automatic pulse(input logic [NUM_SRC-1:0] r);
        @(negedge clk);
        periph_req = r;
        @(negedge clk);
        periph_req = '0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, input logic wide, output logic [DATA_W-1:0] d);
        acc_addr = a; acc_wide = wide;
        #1;
        d = acc_rdata;
        acc_wide = 1'b1;
    endtask

    task automatic clear_status();
        wr(A_MK, 1'b1, 32'hFFFF_FFFF);
        wr(A_ST, 1'b1, 32'h0);
    endtask

    task automatic t_reset();
        logic [DATA_W-1:0] v;
        rd(A_ST, 1'b1, v); check("R1 status", v, 0);
        rd(A_MK, 1'b1, v); check("R1 mask", v, 0);
        check("R1 irq", {31'b0, cpu_irq}, 0);
    endtask

    task automatic t_mask_wide();
        logic [DATA_W-1:0] v;
        wr(A_MK, 1'b1, 32'hDEAD_BEEF);
        rd(A_MK, 1'b1, v); check("R2 mask load", v, 32'hDEAD_BEEF);
    endtask

    task automatic t_mask_narrow();
        logic [DATA_W-1:0] v;
        wr(A_MK, 1'b1, 32'h1234_5678);
        wr(A_MK, 1'b0, 32'hFFFF_ABCD);
        rd(A_MK, 1'b1, v); check("R3 mask narrow", v, 32'h1234_ABCD);
    endtask

    task automatic t_status_ack();
        logic [DATA_W-1:0] v;
        clear_status();
        pulse(20'h007FF);
        wr(A_ST, 1'b1, 32'hFFFF_FF0F);
        rd(A_ST, 1'b1, v); check("R4 ack by value", v, 32'h0000_070F);
        wr(A_MK, 1'b1, 32'h0000_0700);
        wr(A_ST, 1'b1, 32'hFFFF_FFFF);
        rd(A_ST, 1'b1, v); check("R4 ack by mask", v, 32'h0000_0700);
    endtask

    task automatic t_status_narrow();
        logic [DATA_W-1:0] v;
        clear_status();
        pulse(20'hF00FF);
        wr(A_ST, 1'b0, 32'h0000_0000);
        rd(A_ST, 1'b1, v); check("R5 upper kept", v, 32'h000F_0000);
    endtask

    task automatic t_set_priority();
        logic [DATA_W-1:0] v;
        clear_status();
        @(negedge clk);
        acc_wr = 1'b1; acc_addr = A_ST; acc_wide = 1'b1; acc_wdata = 32'h0;
        periph_req = 20'h00008;
        @(negedge clk);
        acc_wr = 1'b0; periph_req = '0;
        rd(A_ST, 1'b1, v); check("R6 set beats ack", v, 32'h0000_0008);
        wr(A_MK, 1'b1, 32'h0);
        pulse(20'h40000);
        rd(A_ST, 1'b1, v); check("R6 set while masked", v, 32'h0004_0008);
    endtask

    task automatic t_force();
        logic [DATA_W-1:0] v;
        clear_status();
        force_serial = 1'b1;
        wr(A_ST, 1'b1, 32'hFFFF_FFFF);
        rd(A_ST, 1'b1, v); check("R7 serial forced", v, 32'h0000_0080);
        force_sound = 1'b1;
        wr(A_ST, 1'b1, 32'hFFFF_FFFF);
        rd(A_ST, 1'b1, v); check("R7 both forced", v, 32'h0000_0280);
        force_serial = 1'b0;
        @(negedge clk); @(negedge clk);
        rd(A_ST, 1'b1, v); check("R7 no write no effect", v, 32'h0000_0280);
        wr(A_ST, 1'b1, 32'h0);
        rd(A_ST, 1'b1, v); check("R7 forced then acked", v, 32'h0);
        force_serial = 1'b1;
        wr(A_MK, 1'b1, 32'hFFFF_FDFF);
        wr(A_ST, 1'b1, 32'hFFFF_FFFF);
        rd(A_ST, 1'b1, v); check("R7 forced bit masked", v, 32'h0000_0080);
        force_serial = 1'b0; force_sound = 1'b0;
    endtask

    task automatic t_irq();
        clear_status();
        wr(A_MK, 1'b1, 32'h0);
        pulse(20'h00020);
        check("R8 masked no irq", {31'b0, cpu_irq}, 0);
        wr(A_MK, 1'b1, 32'h0000_0020);
        check("R8 mask uncovers", {31'b0, cpu_irq}, 1);
        wr(A_MK, 1'b1, 32'h0000_0010);
        check("R8 mask hides", {31'b0, cpu_irq}, 0);
        wr(A_MK, 1'b1, 32'h0000_0020);
        wr(A_ST, 1'b1, 32'h0);
        check("R8 ack drops", {31'b0, cpu_irq}, 0);
    endtask

    task automatic t_other();
        logic [DATA_W-1:0] v;
        clear_status();
        pulse(20'h00003);
        wr(A_MK, 1'b1, 32'h0000_0055);
        wr(12'h078, 1'b1, 32'hFFFF_FFFF);
        wr(12'h072, 1'b0, 32'h0000_0000);
        rd(A_MK, 1'b1, v); check("R9 mask untouched", v, 32'h0000_0055);
        rd(A_ST, 1'b1, v); check("R9 status untouched", v, 32'h0000_0003);
        rd(12'h078, 1'b1, v); check("R9 read other zero", v, 32'h0);
    endtask

    task automatic t_narrow_read();
        logic [DATA_W-1:0] v;
        wr(A_MK, 1'b1, 32'hABCD_1234);
        rd(A_MK, 1'b0, v); check("R10 narrow read", v, 32'h0000_1234);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errs++; checks++;
        $display("FAIL watchdog: actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_mask_wide();
        t_mask_narrow();
        t_status_ack();
        t_status_narrow();
        t_set_priority();
        t_force();
        t_irq();
        t_other();
        t_narrow_read();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule